// File: doc/BRIEF.md
# Watchdog Activity Monitor with Early-Warning Pulse

This block watches a watchdog strobe that arrives already digitised into one of three states: driven low, driven high, or left floating. While the strobe sits at a valid level, a cycle counter measures how long it has gone without changing. If a full timeout period passes with no change, the block fires a short active-low warning pulse. A fixed number of cycles later it latches an active-low fault level. The fault level stays asserted until the strobe toggles between low and high again. If the strobe stays stuck, the warning pulse repeats once per timeout period.

A floating strobe turns the monitor off. It clears any pending fault and any warning pulse and holds the timer at zero. The system supervisor's reset-active flag has the same effect. The flag also drives the fault output high in the same cycle it rises. Once the flag drops, a strobe that is sitting at a valid level counts as a fresh edge, and timing starts from zero. The timeout, the pulse width and the lead time are all parameters counted in clock cycles.

Top module: `wd_pulse_monitor`

## Requirements
- R1: After a synchronous reset, both `fault_n` and `pulse_n` read high, and the state is treated as floating.
- R2: Suppose a valid level (`wd_state` 2'b00 = low, 2'b01 = high) is first sampled at clock edge E0 and then held. `pulse_n` goes low right after edge E0+TIMEOUT_CYC.
- R3: Each warning pulse keeps `pulse_n` low for exactly PULSE_CYC cycles. After that it returns high.
- R4: `fault_n` goes low exactly LEAD_CYC cycles after `pulse_n` goes low for the first missed period.
- R5: Once low, `fault_n` stays low while the level holds. It returns high at the first edge that samples a low/high change. A pulse already running is not cut short by that change.
- R6: Any low/high change restarts the timeout, so the next pulse falls TIMEOUT_CYC edges after the change edge.
- R7: While the strobe is floating, both outputs stay high. Entering the floating state clears a latched fault and a running pulse at the next edge.
- R8: While `sup_rst_act` is high, `fault_n` is high in the same cycle, no pulse is produced, and the timer is held. After release, a held valid level restarts timing as in R2.
- R9: If a valid level stays stuck, a new pulse starts every TIMEOUT_CYC cycles, at edges E0+k·TIMEOUT_CYC with k ≥ 1.
- R10: Both codes 2'b10 and 2'b11 on `wd_state` mean floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_rst_act | input | 1 | Supervisor reset is active (active high) |
| wd_state | input | 2 | Digitised strobe: 00 low, 01 high, 1x floating |
| fault_n | output | 1 | Active-low latched missing-activity level |
| pulse_n | output | 1 | Active-low early-warning pulse |

## Verification
Every result is timed from the clock edge that first samples a new strobe value, called E0 here. The pulse falls after E0+TIMEOUT_CYC and rises PULSE_CYC edges later. The fault level falls LEAD_CYC edges after the pulse falls and rises after the single edge that samples a change. The supervisor flag forces `fault_n` high combinationally, with no edge in between. The bench drives inputs on the falling clock edge and samples at the next falling edge. This places each sample exactly one rising edge later. For every hold length up to three timeout periods, the bench computes the expected output values arithmetically as a function of the number of edges since E0. It samples the combinational supervisor path one time unit after driving the flag.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

    typedef enum logic [1:0] {
        WD_LOW       = 2'b00,
        WD_HIGH      = 2'b01,
        WD_FLOAT     = 2'b10,
        WD_FLOAT_ALT = 2'b11
    } wd_lvl_e;

    typedef struct packed {
        logic chg;    // sampled state differs from previous sample
        logic valid;  // current state is a driven level (R10)
    } wd_evt_t;

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic logic lvl_is_valid(input logic [1:0] s);
        return ~s[1];
    endfunction

endpackage

// File: rtl/wdm_edge_det.sv
module wdm_edge_det
    import wdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic [1:0] wd_state,
    output wd_evt_t    evt
);

    logic [1:0] prev_q;

    // Forcing the previous sample to floating makes a held level look like a new edge
    always_ff @(posedge clk) begin
        if (rst || hold) prev_q <= WD_FLOAT;
        else             prev_q <= wd_state;
    end

    always_comb begin
        evt.chg   = (wd_state != prev_q);
        evt.valid = lvl_is_valid(wd_state);
    end

    // R8: after the supervisor flag drops, a valid level restarts timing
    p_release_restart_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(hold) && evt.valid) |-> evt.chg);

endmodule

// File: rtl/wdm_timeout.sv
module wdm_timeout
    import wdm_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 80_000_000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    hold,
    input  wd_evt_t evt,
    output logic    expire
);

    localparam int unsigned CW = cnt_bits(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          restart;

    always_comb begin
        restart = hold | ~evt.valid | evt.chg;
        expire  = ~restart & (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || restart)    cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + CW'(1);
    end

    // R2: the idle counter never passes the last count of a period
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R7: a floating strobe holds the timer at zero
    p_float_restart_r7: assert property (@(posedge clk) disable iff (rst)
        !evt.valid |=> cnt_q == '0);

endmodule

// File: rtl/wdm_oneshot.sv
module wdm_oneshot
    import wdm_pkg::*;
#(
    parameter int unsigned WIDTH_CYC = 50_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic fire,
    output logic active
);

    localparam int unsigned CW = cnt_bits(WIDTH_CYC);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || clear)     left_q <= '0;
        else if (fire)        left_q <= CW'(WIDTH_CYC);
        else if (left_q != 0) left_q <= left_q - CW'(1);
    end

    assign active = (left_q != '0);

    // R3: a fire starts the pulse on the next cycle
    p_fire_starts_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && !clear) |=> active);

    // R3: the pulse ends after the final counted cycle
    p_pulse_ends_r3: assert property (@(posedge clk) disable iff (rst)
        (left_q == CW'(1) && !fire && !clear) |=> !active);

endmodule

// File: rtl/wdm_fault_latch.sv
module wdm_fault_latch
    import wdm_pkg::*;
#(
    parameter int unsigned LEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic arm,
    output logic fault
);

    localparam int unsigned CW = cnt_bits(LEAD_CYC);

    logic [CW-1:0] lead_q;
    logic          fault_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lead_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            if (arm)              lead_q <= CW'(LEAD_CYC);
            else if (lead_q != 0) lead_q <= lead_q - CW'(1);
            if (lead_q == CW'(1)) fault_q <= 1'b1;
        end
    end

    assign fault = fault_q;

    // R4: the fault is only set when the lead delay runs out
    p_fault_after_lead_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_q) |-> $past(lead_q == CW'(1)));

    // R5: a clear request drops the fault on the next cycle
    p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
        clear |=> !fault_q);

endmodule

// File: rtl/wd_pulse_monitor.sv
module wd_pulse_monitor
    import wdm_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 80_000_000,
    parameter int unsigned PULSE_CYC   = 50_000,
    parameter int unsigned LEAD_CYC    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sup_rst_act,
    input  logic [1:0] wd_state,
    output logic       fault_n,
    output logic       pulse_n
);

    wd_evt_t evt;
    logic    expire;
    logic    pulse_act;
    logic    fault_act;
    logic    clr_state;
    logic    clr_fault;

    always_comb begin
        clr_state = sup_rst_act | ~evt.valid;
        clr_fault = clr_state | evt.chg;
    end

    wdm_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .hold     (sup_rst_act),
        .wd_state (wd_state),
        .evt      (evt)
    );

    wdm_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .hold   (sup_rst_act),
        .evt    (evt),
        .expire (expire)
    );

    wdm_oneshot #(.WIDTH_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .clear  (clr_state),
        .fire   (expire),
        .active (pulse_act)
    );

    wdm_fault_latch #(.LEAD_CYC(LEAD_CYC)) u_fault (
        .clk   (clk),
        .rst   (rst),
        .clear (clr_fault),
        .arm   (expire),
        .fault (fault_act)
    );

    assign pulse_n = ~pulse_act;
    assign fault_n = ~(fault_act & ~sup_rst_act);

    // R8: one cycle after the supervisor flag, both outputs are inactive
    p_sup_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        sup_rst_act |=> (pulse_n && fault_n));

    // R7: after a floating sample both outputs are inactive
    p_float_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !evt.valid |=> (pulse_n && fault_n));

endmodule

// File: tb/wd_pulse_monitor_tb_top.sv
module wd_pulse_monitor_tb_top;

    localparam int T = 12;
    localparam int P = 3;
    localparam int L = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sup = 1'b0;
    logic [1:0] wds = 2'b10;
    logic       fault_n;
    logic       pulse_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    wd_pulse_monitor #(.TIMEOUT_CYC(T), .PULSE_CYC(P), .LEAD_CYC(L)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .sup_rst_act (sup),
        .wd_state    (wds),
        .fault_n     (fault_n),
        .pulse_n     (pulse_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // expected pulse_n j edges after E0 when pulses could start up to edge 'last'
    function automatic logic pexp(input int j, input int last);
        for (int s = T; s <= last; s += T)
            if (j >= s && j < s + P) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic fexp(input int j);
        return (j >= T + L) ? 1'b0 : 1'b1;
    endfunction

    initial begin
        // R1: reset state
        rst = 1'b1; wds = 2'b01;
        repeat (3) tick();
        chk("R1 fault_n in reset", fault_n, 1'b1);
        chk("R1 pulse_n in reset", pulse_n, 1'b1);
        rst = 1'b0;

        // R10/R7: both floating codes keep outputs high
        for (int c = 2; c < 4; c++) begin
            wds = 2'(c);
            for (int j = 0; j < 3 * T; j++) begin
                tick();
                chk("R10 float fault_n", fault_n, 1'b1);
                chk("R10 float pulse_n", pulse_n, 1'b1);
            end
        end

        // Sweep: each level and each hold length
        for (int lv = 0; lv < 2; lv++) begin
            for (int h = 1; h <= 3 * T; h++) begin
                wds = 2'b10;
                tick();
                chk("R7 float clears fault", fault_n, 1'b1);
                chk("R7 float clears pulse", pulse_n, 1'b1);
                tick();
                wds = 2'(lv);
                for (int j = 0; j <= h; j++) begin
                    tick();
                    chk("R2/R3/R9 pulse_n", pulse_n, pexp(j, j));
                    chk("R4 fault_n", fault_n, fexp(j));
                end
                wds = 2'(lv ^ 1);
                tick();
                chk("R5 change clears fault", fault_n, 1'b1);
                chk("R5 running pulse kept", pulse_n, pexp(h + 1, h));
                for (int j2 = 1; j2 <= T + L; j2++) begin
                    tick();
                    chk("R6 restart pulse_n", pulse_n,
                        pexp(h + 1 + j2, h) & pexp(j2, j2));
                    chk("R6 restart fault_n", fault_n, fexp(j2));
                end
            end
        end

        // R8: supervisor flag
        wds = 2'b10; repeat (2) tick();
        wds = 2'b01;
        for (int j = 0; j <= T + L; j++) tick();
        chk("R8 fault low before flag", fault_n, 1'b0);
        sup = 1'b1;
        #1;
        chk("R8 flag forces fault_n", fault_n, 1'b1);
        for (int j = 0; j < 2 * T; j++) begin
            tick();
            chk("R8 no pulse under flag", pulse_n, 1'b1);
            chk("R8 fault high under flag", fault_n, 1'b1);
        end
        sup = 1'b0;
        for (int j = 0; j <= T + L + 1; j++) begin
            tick();
            chk("R8 restart pulse_n", pulse_n, pexp(j, j));
            chk("R8 restart fault_n", fault_n, fexp(j));
        end

        // R1: reset during a fault, then restart from the held level
        rst = 1'b1;
        tick();
        chk("R1 reset clears fault", fault_n, 1'b1);
        chk("R1 reset clears pulse", pulse_n, 1'b1);
        rst = 1'b0;
        for (int j = 0; j <= 2 * T; j++) begin
            tick();
            chk("R1 post-reset pulse_n", pulse_n, pexp(j, j));
            chk("R1 post-reset fault_n", fault_n, fexp(j));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule